// File: doc/BRIEF.md
# SMBus Indexed Register Target

This block is a small SMBus target that gives a host access to six eight-bit registers inside a clock-control block. One register holds the control bits that steer the PLL. Two registers are identity bytes that cannot be written. One register holds the number of bytes a read returns. A fast system clock samples SCL and SDA, so the whole block runs in that single clock domain. SDA is driven only as an open-drain pull-down enable.

Every transfer is an indexed block transfer. A write carries three things after the address: a start index, a byte count, and then that many data bytes. The data bytes land in consecutive registers. A read first sends the start index in a write phase. After a repeated START and the read address, the target sends the programmed byte count and then the data bytes, starting at the chosen index.

Top module: `cfgbank_smbus_target`

## Requirements
- R1: After reset, register 0 holds 0x83, registers 1 and 2 hold 0x00, and register 5 (the read count) holds 0x06.
- R2: The target answers only the seven-bit address 0x6A, which is byte 0xD4 for a write and byte 0xD5 for a read. It ACKs by pulling SDA low in the ninth clock. For any other address it leaves the ACK slot high and stays silent until the next START.
- R3: A write is made of address, index N, count X and then data. Each data byte is ACKed, and the bytes are stored in registers N, N+1, … N+X-1. Any data byte after the X-th is NACKed and not stored.
- R4: A read is made of address+W, index N, repeated START and address+R. The target then sends the value of register 5, followed by that many bytes from registers N upward. After the last of those bytes it releases SDA, so any further byte reads as 0xFF.
- R5: When the host NACKs a byte during a read, the target stops driving SDA. The next byte the host clocks reads as 0xFF.
- R6: Register 3 always reads 0x11 and register 4 always reads 0x06. A write to either one is ACKed and has no effect.
- R7: An index of 6 or above holds no register. Writes there are ACKed and discarded, and reads there return 0x00.
- R8: Three bits of register 0 drive outputs: bit 7 drives pll_pin_ctrl, bit 1 drives pll_bw_high and bit 0 drives pll_enable.
- R9: A START or a STOP aborts the current transfer at any bit. Bytes already stored are kept and a partly received byte is dropped. The index survives a repeated START.
- R10: The target changes SDA only while SCL is low. It shifts data MSB first.
- R11: Register 5 is writable. A new value changes how many data bytes the next read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level (wired-AND bus) |
| sda_oe | output | 1 | 1 pulls SDA low |
| pll_pin_ctrl | output | 1 | Register 0 bit 7: PLL controlled by pins |
| pll_bw_high | output | 1 | Register 0 bit 1: 1 high bandwidth, 0 low |
| pll_enable | output | 1 | Register 0 bit 0: 1 PLL used, 0 bypass |

## Verification
The bench attacks the count logic at both ends. A byte past the declared write count must be NACKed and dropped, and a design that keeps storing it would corrupt the register after the window. A read with the count set to 3 or to 0 must release SDA on time, and an off-by-one there would either hold the bus low or send one byte too many. Writes aimed at the identity bytes and at missing indexes check that read-only decoding does not alias onto a neighbour. A transfer aborted by a START partway through a byte must keep the byte stored before it and drop the partial one. Reads rely on the index that was written before the repeated START, so a design that clears the index on START would read register 0.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef enum logic [1:0] {
        FLD_ADDR,
        FLD_INDEX,
        FLD_COUNT,
        FLD_DATA
    } field_e;

    localparam logic [6:0] DEV_ADDR7    = 7'h6A;
    localparam int         IDX_CTL      = 0;
    localparam int         IDX_IDENT    = 3;
    localparam int         IDX_DEVID    = 4;
    localparam int         IDX_RDCNT    = 5;
    localparam logic [7:0] CTL_RESET    = 8'h83;
    localparam logic [7:0] IDENT_VALUE  = 8'h11;
    localparam logic [7:0] DEVID_VALUE  = 8'h06;
    localparam logic [7:0] RDCNT_RESET  = 8'h06;
    localparam int         BIT_PINSEL   = 7;
    localparam int         BIT_BW       = 1;
    localparam int         BIT_PLLON    = 0;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [TOP:0] scl;
        logic [TOP:0] sda;
        logic         scl_p;
        logic         sda_p;
    } sync_t;

    sync_t d, q;
    logic  scl_now;

    always_comb begin
        d       = q;
        d.scl   = {q.scl[TOP-1:0], scl_i};
        d.sda   = {q.sda[TOP-1:0], sda_i};
        d.scl_p = q.scl[TOP];
        d.sda_p = q.sda[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_now    = q.scl[TOP];
    assign sda_lvl    = q.sda[TOP];
    assign scl_rise   = scl_now & ~q.scl_p;
    assign scl_fall   = ~scl_now & q.scl_p;
    assign cond_start = scl_now & q.scl_p & q.sda_p & ~sda_lvl;
    assign cond_stop  = scl_now & q.scl_p & ~q.sda_p & sda_lvl;

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import smb_cfg_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 6,
    parameter int IW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] cnt_val,
    output logic          pin_sel,
    output logic          bw_high,
    output logic          pll_on
);
    localparam int AW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] r;
    } bank_t;

    function automatic logic [NREG-1:0][DW-1:0] reset_image();
        logic [NREG-1:0][DW-1:0] img;
        img            = '0;
        img[IDX_CTL]   = DW'(CTL_RESET);
        img[IDX_IDENT] = DW'(IDENT_VALUE);
        img[IDX_DEVID] = DW'(DEVID_VALUE);
        img[IDX_RDCNT] = DW'(RDCNT_RESET);
        return img;
    endfunction

    localparam logic [NREG-1:0][DW-1:0] RST_IMG = reset_image();

    bank_t         d, q;
    logic [NREG-1:0] writable;

    // per-register write permission; identity bytes are fixed
    for (genvar g = 0; g < NREG; g++) begin : g_perm
        if (g == IDX_IDENT || g == IDX_DEVID) begin : g_ro
            assign writable[g] = 1'b0;
        end else begin : g_rw
            assign writable[g] = 1'b1;
        end
    end

    always_comb begin
        d = q;
        if (wr_en && (wr_idx < IW'(NREG)) && writable[wr_idx[AW-1:0]])
            d.r[wr_idx[AW-1:0]] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{r: RST_IMG};
        else        q <= d;
    end

    assign rd_data = (rd_idx < IW'(NREG)) ? q.r[rd_idx[AW-1:0]] : '0;
    assign cnt_val = q.r[IDX_RDCNT];
    assign pin_sel = q.r[IDX_CTL][BIT_PINSEL];
    assign bw_high = q.r[IDX_CTL][BIT_BW];
    assign pll_on  = q.r[IDX_CTL][BIT_PLLON];

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import smb_cfg_pkg::*;
#(
    parameter int         DW    = 8,
    parameter int         IW    = 8,
    parameter logic [6:0] ADDR7 = DEV_ADDR7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          cond_start,
    input  logic          cond_stop,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] cnt_val,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic [IW-1:0] rd_idx
);
    localparam int BW = $clog2(DW + 1);

    typedef struct packed {
        phase_e        ph;
        field_e        fld;
        logic [DW-1:0] sh;
        logic [BW-1:0] bits;
        logic [IW-1:0] idx;
        logic [DW-1:0] wr_left;
        logic [DW-1:0] rd_left;
        logic          rd_mode;
        logic          ack_ok;
        logic          oe;
    } fsm_t;

    fsm_t d, q;
    logic wr_pulse;

    always_comb begin
        d        = q;
        wr_pulse = 1'b0;
        if (cond_start) begin
            d.ph   = PH_RX;
            d.fld  = FLD_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (cond_stop) begin
            d.ph = PH_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.ph)
                PH_RX: begin
                    if (scl_rise && q.bits < BW'(DW)) begin
                        d.sh   = {q.sh[DW-2:0], sda_lvl};
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == BW'(DW)) begin
                        d.oe = 1'b1;
                        d.ph = PH_RX_ACK;
                        unique case (q.fld)
                            FLD_ADDR: begin
                                if (q.sh[DW-1:1] == ADDR7) begin
                                    d.rd_mode = q.sh[0];
                                end else begin
                                    d.oe = 1'b0;
                                    d.ph = PH_IDLE;
                                end
                            end
                            FLD_INDEX: d.idx     = IW'(q.sh);
                            FLD_COUNT: d.wr_left = q.sh;
                            default: begin
                                if (q.wr_left != '0) begin
                                    wr_pulse  = 1'b1;
                                    d.idx     = q.idx + 1'b1;
                                    d.wr_left = q.wr_left - 1'b1;
                                end else begin
                                    d.oe = 1'b0;
                                    d.ph = PH_IDLE;
                                end
                            end
                        endcase
                    end
                end
                PH_RX_ACK: begin
                    if (scl_fall) begin
                        d.oe   = 1'b0;
                        d.bits = '0;
                        if (q.fld == FLD_ADDR && q.rd_mode) begin
                            d.ph      = PH_TX;
                            d.sh      = cnt_val;
                            d.rd_left = cnt_val;
                            d.oe      = ~cnt_val[DW-1];
                        end else begin
                            d.ph = PH_RX;
                            unique case (q.fld)
                                FLD_ADDR:  d.fld = FLD_INDEX;
                                FLD_INDEX: d.fld = FLD_COUNT;
                                default:   d.fld = FLD_DATA;
                            endcase
                        end
                    end
                end
                PH_TX: begin
                    if (scl_rise) begin
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall) begin
                        if (q.bits == BW'(DW)) begin
                            d.oe = 1'b0;
                            d.ph = PH_TX_ACK;
                        end else begin
                            d.sh = {q.sh[DW-2:0], 1'b0};
                            d.oe = ~q.sh[DW-2];
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_rise) begin
                        d.ack_ok = ~sda_lvl;
                    end else if (scl_fall) begin
                        d.bits = '0;
                        if (q.ack_ok && q.rd_left != '0) begin
                            d.ph      = PH_TX;
                            d.sh      = rd_data;
                            d.oe      = ~rd_data[DW-1];
                            d.idx     = q.idx + 1'b1;
                            d.rd_left = q.rd_left - 1'b1;
                        end else begin
                            d.ph = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.ph      <= PH_IDLE;
            q.fld     <= FLD_ADDR;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_en   = wr_pulse;
    assign wr_idx  = q.idx;
    assign wr_data = q.sh;
    assign rd_idx  = q.idx;

endmodule

// File: rtl/cfgbank_smbus_target.sv
module cfgbank_smbus_target
    import smb_cfg_pkg::*;
#(
    parameter int DW          = 8,
    parameter int NREG        = 6,
    parameter int IW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic pll_pin_ctrl,
    output logic pll_bw_high,
    output logic pll_enable
);
    logic          sda_lvl, scl_rise, scl_fall, cond_start, cond_stop;
    logic          wr_en;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [DW-1:0] wr_data, rd_data, cnt_val;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .cond_start (cond_start),
        .cond_stop  (cond_stop)
    );

    smb_xfer_fsm #(.DW(DW), .IW(IW), .ADDR7(DEV_ADDR7)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_lvl    (sda_lvl),
        .cond_start (cond_start),
        .cond_stop  (cond_stop),
        .rd_data    (rd_data),
        .cnt_val    (cnt_val),
        .sda_oe     (sda_oe),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx)
    );

    cfg_regbank #(.DW(DW), .NREG(NREG), .IW(IW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cnt_val (cnt_val),
        .pin_sel (pll_pin_ctrl),
        .bw_high (pll_bw_high),
        .pll_on  (pll_enable)
    );

endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic cond_start,
    input logic cond_stop,
    input logic wr_en,
    input logic pll_pin_ctrl,
    input logic pll_bw_high,
    input logic pll_enable
);
    AST_RESET_CTL: assert property (@(posedge clk)
        !rst_n |=> (pll_pin_ctrl && pll_bw_high && pll_enable)); // R1

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i); // R10

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_stop |=> !sda_oe); // R9

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_start |=> !sda_oe); // R9

    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3

    AST_WRITE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_i); // R3

endmodule

bind cfgbank_smbus_target smb_target_chk u_chk (.*);

// File: tb/sim_cfgbank_smbus_target.sv
module sim_cfgbank_smbus_target;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_host = 1'b1;
    logic sda_oe, pin_ctrl, bw_high, pll_en;
    logic sda_bus;
    logic cmp_en = 1'b0;
    int   n_tests = 0;
    int   n_fail = 0;
    logic [7:0] mdl [0:5];

    assign sda_bus = sda_host & ~sda_oe;

    always #2 clk = ~clk;

    cfgbank_smbus_target u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_bus),
        .sda_oe       (sda_oe),
        .pll_pin_ctrl (pin_ctrl),
        .pll_bw_high  (bw_high),
        .pll_enable   (pll_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mdl_read(input logic [7:0] idx);
        return (idx < 8'd6) ? mdl[idx[2:0]] : 8'h00;
    endfunction

    task automatic mdl_write(input logic [7:0] idx, input logic [7:0] v);
        if (idx < 8'd6 && idx != 8'd3 && idx != 8'd4) mdl[idx[2:0]] = v;
    endtask

    // idle-time comparison of control outputs and SDA against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            check(pin_ctrl == mdl[0][7] && bw_high == mdl[0][1] && pll_en == mdl[0][0],
                  "R8", "ctl outputs", {pin_ctrl, bw_high, pll_en},
                  {mdl[0][7], mdl[0][1], mdl[0][0]});
            check(sda_oe == 1'b0, "R5", "idle sda_oe", sda_oe, 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_host = 1'b1; tick(Q);
        scl = 1'b1;      tick(Q);
        sda_host = 1'b0; tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic bus_stop;
        sda_host = 1'b0; tick(Q);
        scl = 1'b1;      tick(Q);
        sda_host = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_host = b; tick(Q);
        scl = 1'b1;   tick(2 * Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_host = 1'b1; tick(Q);
        scl = 1'b1;      tick(Q);
        b = sda_bus;     tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(~ack_it);
    endtask

    task automatic wr_xfer(input logic [7:0] idx, input logic [7:0] cnt,
                           input logic [7:0] data[$], input string req);
        logic ack;
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hD4, ack); check(ack, req, "write addr ack", ack, 1);
        send_byte(idx, ack);   check(ack, req, "index ack", ack, 1);
        send_byte(cnt, ack);   check(ack, req, "count ack", ack, 1);
        foreach (data[i]) begin
            logic exp_ack;
            exp_ack = (i < int'(cnt));
            send_byte(data[i], ack);
            check(ack == exp_ack, req, "data ack", ack, exp_ack);
            if (exp_ack) mdl_write(idx + 8'(i), data[i]);
        end
        bus_stop;
        tick(4);
        cmp_en = 1'b1;
    endtask

    // take < 0: read every counted byte with ACK; else NACK the take-th byte
    task automatic rd_xfer(input logic [7:0] idx, input int take, input string req);
        logic ack;
        logic [7:0] v;
        logic [7:0] c;
        int n;
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hD4, ack); check(ack, req, "write addr ack", ack, 1);
        send_byte(idx, ack);   check(ack, req, "index ack", ack, 1);
        bus_start;
        send_byte(8'hD5, ack); check(ack, req, "read addr ack", ack, 1);
        recv_byte(1'b1, c);
        check(c == mdl[5], req, "count byte", c, mdl[5]);
        n = (take < 0) ? int'(mdl[5]) : take;
        for (int k = 0; k < n; k++) begin
            logic [7:0] e;
            e = mdl_read(idx + 8'(k));
            recv_byte((take < 0) ? 1'b1 : (k < n - 1), v);
            check(v == e, req, "read data", v, e);
        end
        recv_byte(1'b0, v);
        check(v == 8'hFF, req, "bus released after read", v, 8'hFF);
        bus_stop;
        tick(4);
        cmp_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        mdl[0] = 8'h83; mdl[1] = 8'h00; mdl[2] = 8'h00;
        mdl[3] = 8'h11; mdl[4] = 8'h06; mdl[5] = 8'h06;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1 reset state at the ports
        check(pin_ctrl && bw_high && pll_en, "R1", "reset ctl outputs",
              {pin_ctrl, bw_high, pll_en}, 3'b111);
        check(!sda_oe, "R1", "reset sda_oe", sda_oe, 0);
        cmp_en = 1'b1;

        // R1 R4 R10: default count and reset image, read MSB first
        rd_xfer(8'd0, -1, "R4 R10 R1");

        // R3 R8: single byte into the control register
        wr_xfer(8'd0, 8'd1, '{8'h02}, "R3");
        check(!pin_ctrl && bw_high && !pll_en, "R8", "ctl after 0x02",
              {pin_ctrl, bw_high, pll_en}, 3'b010);

        // R2: foreign address gets NACK and silence
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hA0, ack); check(!ack, "R2", "foreign addr nack", ack, 0);
        send_byte(8'h00, ack); check(!ack, "R2", "silent after nack", ack, 0);
        bus_stop;
        cmp_en = 1'b1;

        // R6 R3: span over the identity bytes, fifth byte beyond count
        wr_xfer(8'd1, 8'd4, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, "R6 R3");
        rd_xfer(8'd0, -1, "R6");

        // R11: shorter read count
        wr_xfer(8'd5, 8'd1, '{8'h03}, "R11");
        rd_xfer(8'd1, -1, "R11");

        // R7: missing indexes
        wr_xfer(8'd7, 8'd1, '{8'hAA}, "R7");
        rd_xfer(8'd4, -1, "R7");

        // R5: host NACK after the first data byte
        rd_xfer(8'd0, 1, "R5");

        // R9: START in the middle of the second data byte
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hD4, ack); check(ack, "R9", "addr ack", ack, 1);
        send_byte(8'h00, ack); check(ack, "R9", "index ack", ack, 1);
        send_byte(8'h02, ack); check(ack, "R9", "count ack", ack, 1);
        send_byte(8'h80, ack); check(ack, "R9", "data ack", ack, 1);
        mdl_write(8'd0, 8'h80);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start;
        bus_stop;
        tick(4);
        cmp_en = 1'b1;
        check(pin_ctrl && !bw_high && !pll_en, "R9", "ctl after abort",
              {pin_ctrl, bw_high, pll_en}, 3'b100);
        rd_xfer(8'd0, -1, "R9");

        // R4: zero count releases right after the count byte
        wr_xfer(8'd5, 8'd1, '{8'h00}, "R4");
        rd_xfer(8'd2, -1, "R4");

        tick(10);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule